// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the 32-bit effective address of a memory operand for a register-memory processor. Each request supplies a base register value, an index register value, a two-bit scale code, a displacement and an addressing-mode code. The block adds these together according to the mode. The displacement is either a short signed byte or a full 32-bit word. The index can be multiplied by 1, 2, 4 or 8 with a left shift.

A request is either a memory operand or a load-effective-address operation. A memory operand raises the read strobe. A load-effective-address operation raises a register-write strobe and no read strobe, so the same address appears as data for the destination register. By default the result comes out of one pipeline register, one cycle after the request. A parameter removes that register, and the block is then purely combinational.

Top module: `scaled_agu`

## Requirements
- R1: Mode code 2'b00 (base plus displacement) gives `effAddr = baseVal + displacement`.
- R2: Mode code 2'b01 (base plus index) gives `effAddr = baseVal + indexVal`. In this mode the displacement input and the scale code have no effect.
- R3: Mode code 2'b10 (scaled index) gives `effAddr = baseVal + indexVal*S`. The displacement is ignored. The scale code selects S as follows: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8.
- R4: Mode code 2'b11 (scaled index plus displacement) gives `effAddr = baseVal + indexVal*S + displacement`, with S as in R3.
- R5: When `dispWide` is 1, the displacement is all 32 bits of `dispVal`. When `dispWide` is 0, the displacement is `dispVal[7:0]` sign-extended to 32 bits, and `dispVal[31:8]` is ignored.
- R6: In mode 2'b00 the index input has no effect on the address.
- R7: All address arithmetic wraps modulo 2^32, and no overflow is reported.
- R8: A request with `leaReq`=1 drives `leaWrite`=1 and `memRead`=0, with the computed address on `effAddr`.
- R9: A request with `leaReq`=0 drives `memRead`=1 and `leaWrite`=0. The two strobes are never high together.
- R10: With REGISTERED=1 the result appears one clock after the request is sampled. When there was no request in the previous cycle, or while `rstN` is low, `effAddr`, `memRead` and `leaWrite` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| leaReq | input | 1 | 1 = load-effective-address, 0 = memory operand |
| modeSel | input | 2 | Addressing mode code |
| scaleSel | input | 2 | Index scale code (shift 0..3) |
| dispWide | input | 1 | 1 = 32-bit displacement, 0 = signed byte |
| baseVal | input | 32 | Base register value |
| indexVal | input | 32 | Index register value |
| dispVal | input | 32 | Displacement immediate |
| effAddr | output | 32 | Effective address |
| memRead | output | 1 | Memory read strobe |
| leaWrite | output | 1 | Register write strobe for the address-as-data result |

## Verification
The hardest case to reach is a displacement or index that should be ignored but carries a value large enough to move the sum. Examples are a short displacement with nonzero upper bits, a displacement in an index-only mode, and an index in the base-plus-displacement mode. The stimulus drives these with all-ones or patterned garbage, so that any leak changes the address. Carry wrap is forced with a base near 2^32 together with a positive scaled index. Back-to-back requests that alternate the mode, the scale and the load-effective-address flag then mix all four modes while the reference model checks the result on every cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    MODE_BASE_DISP   = 2'b00,
    MODE_BASE_INDEX  = 2'b01,
    MODE_SCALED      = 2'b10,
    MODE_SCALED_DISP = 2'b11
  } aguMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fire;
    logic isLea;
    logic useIndex;
    logic useScale;
    logic useDisp;
  } aguStrobes_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic        reqValid,
  input  logic        leaReq,
  input  logic [1:0]  modeSel,
  output aguStrobes_t strobes
);

  aguMode_e modeDec;

  always_comb begin
    modeDec          = aguMode_e'(modeSel);
    strobes          = '0;
    strobes.fire     = reqValid;
    strobes.isLea    = reqValid & leaReq;
    unique case (modeDec)
      MODE_BASE_DISP: begin
        strobes.useDisp  = 1'b1;
      end
      MODE_BASE_INDEX: begin
        strobes.useIndex = 1'b1;
      end
      MODE_SCALED: begin
        strobes.useIndex = 1'b1;
        strobes.useScale = 1'b1;
      end
      MODE_SCALED_DISP: begin
        strobes.useIndex = 1'b1;
        strobes.useScale = 1'b1;
        strobes.useDisp  = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/agu_dpath.sv
module agu_dpath
  import agu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SHORT_W    = 8,
  parameter int SCALE_W    = 2,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  aguStrobes_t       strobes,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic              dispWide,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [ADDR_W-1:0] dispVal,
  output logic [ADDR_W-1:0] effAddr,
  output logic              memRead,
  output logic              leaWrite
);

  localparam int EXT_W = ADDR_W - SHORT_W;

  logic [ADDR_W-1:0]  dispExt;
  logic [ADDR_W-1:0]  dispTerm;
  logic [ADDR_W-1:0]  indexTerm;
  logic [SCALE_W-1:0] shiftAmt;
  logic [ADDR_W-1:0]  sumNext;
  logic [ADDR_W-1:0]  addrNext;
  logic               readNext;
  logic               leaNext;

  // displacement width select with sign extension of the short form
  always_comb begin
    if (dispWide) dispExt = dispVal;
    else          dispExt = {{EXT_W{dispVal[SHORT_W-1]}}, dispVal[SHORT_W-1:0]};
    dispTerm = strobes.useDisp ? dispExt : '0;
  end

  // index scaling as a left shift
  always_comb begin
    shiftAmt  = strobes.useScale ? scaleSel : '0;
    indexTerm = strobes.useIndex ? (indexVal << shiftAmt) : '0;
  end

  // three-input add, wraps modulo 2^ADDR_W
  always_comb begin
    sumNext  = baseVal + indexTerm + dispTerm;
    addrNext = strobes.fire ? sumNext : '0;
    readNext = strobes.fire & ~strobes.isLea;
    leaNext  = strobes.isLea;
  end

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          effAddr  <= '0;
          memRead  <= 1'b0;
          leaWrite <= 1'b0;
        end else begin
          effAddr  <= addrNext;
          memRead  <= readNext;
          leaWrite <= leaNext;
        end
      end
    end else begin : g_comb
      always_comb begin
        effAddr  = rstN ? addrNext : '0;
        memRead  = rstN & readNext;
        leaWrite = rstN & leaNext;
      end
    end
  endgenerate

endmodule

// File: rtl/scaled_agu.sv
module scaled_agu
  import agu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SHORT_W    = 8,
  parameter int SCALE_W    = 2,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              leaReq,
  input  logic [1:0]        modeSel,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic              dispWide,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [ADDR_W-1:0] dispVal,
  output logic [ADDR_W-1:0] effAddr,
  output logic              memRead,
  output logic              leaWrite
);

  aguStrobes_t strobes;

  agu_ctrl u_ctrl (
    .reqValid (reqValid),
    .leaReq   (leaReq),
    .modeSel  (modeSel),
    .strobes  (strobes)
  );

  agu_dpath #(
    .ADDR_W     (ADDR_W),
    .SHORT_W    (SHORT_W),
    .SCALE_W    (SCALE_W),
    .REGISTERED (REGISTERED)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .scaleSel (scaleSel),
    .dispWide (dispWide),
    .baseVal  (baseVal),
    .indexVal (indexVal),
    .dispVal  (dispVal),
    .effAddr  (effAddr),
    .memRead  (memRead),
    .leaWrite (leaWrite)
  );

endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int ADDR_W     = 32,
  parameter int SCALE_W    = 2,
  parameter bit REGISTERED = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              leaReq,
  input logic [1:0]        modeSel,
  input logic [SCALE_W-1:0] scaleSel,
  input logic              dispWide,
  input logic [ADDR_W-1:0] baseVal,
  input logic [ADDR_W-1:0] indexVal,
  input logic [ADDR_W-1:0] dispVal,
  input logic [ADDR_W-1:0] effAddr,
  input logic              memRead,
  input logic              leaWrite
);

  logic              prevFire, prevLea, prevWide;
  logic [1:0]        prevMode;
  logic [ADDR_W-1:0] prevBase, prevIndex, prevDisp;

  generate
    if (REGISTERED) begin : g_hist
      always_ff @(posedge clk) begin
        if (!rstN) begin
          prevFire  <= 1'b0;
          prevLea   <= 1'b0;
          prevWide  <= 1'b0;
          prevMode  <= '0;
          prevBase  <= '0;
          prevIndex <= '0;
          prevDisp  <= '0;
        end else begin
          prevFire  <= reqValid;
          prevLea   <= leaReq;
          prevWide  <= dispWide;
          prevMode  <= modeSel;
          prevBase  <= baseVal;
          prevIndex <= indexVal;
          prevDisp  <= dispVal;
        end
      end
    end else begin : g_now
      always_comb begin
        prevFire  = reqValid;
        prevLea   = leaReq;
        prevWide  = dispWide;
        prevMode  = modeSel;
        prevBase  = baseVal;
        prevIndex = indexVal;
        prevDisp  = dispVal;
      end
    end
  endgenerate

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(memRead && leaWrite)); // R9
  AST_LEA_NO_READ: assert property (@(posedge clk) disable iff (!rstN) (prevFire && prevLea) |-> (leaWrite && !memRead)); // R8
  AST_READ_ISSUED: assert property (@(posedge clk) disable iff (!rstN) (prevFire && !prevLea) |-> (memRead && !leaWrite)); // R9
  AST_IDLE_QUIET:  assert property (@(posedge clk) disable iff (!rstN) !prevFire |-> (!memRead && !leaWrite && effAddr == '0)); // R10
  AST_TWO_REG_SUM: assert property (@(posedge clk) disable iff (!rstN) (prevFire && prevMode == 2'b01) |-> (effAddr == prevBase + prevIndex)); // R2
  AST_INDEX_IGNORED: assert property (@(posedge clk) disable iff (!rstN) (prevFire && prevMode == 2'b00 && prevWide) |-> (effAddr == prevBase + prevDisp)); // R6

endmodule

bind scaled_agu agu_chk #(
  .ADDR_W     (ADDR_W),
  .SCALE_W    (SCALE_W),
  .REGISTERED (REGISTERED)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .leaReq   (leaReq),
  .modeSel  (modeSel),
  .scaleSel (scaleSel),
  .dispWide (dispWide),
  .baseVal  (baseVal),
  .indexVal (indexVal),
  .dispVal  (dispVal),
  .effAddr  (effAddr),
  .memRead  (memRead),
  .leaWrite (leaWrite)
);

// File: tb/scaled_agu_tb.sv
module scaled_agu_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        leaReq = 1'b0;
  logic [1:0]  modeSel = '0;
  logic [1:0]  scaleSel = '0;
  logic        dispWide = 1'b0;
  logic [31:0] baseVal = '0;
  logic [31:0] indexVal = '0;
  logic [31:0] dispVal = '0;
  logic [31:0] effAddr;
  logic        memRead;
  logic        leaWrite;

  int    compared = 0;
  int    mismatched = 0;
  bit    done = 1'b0;
  string curTag = "R10";

  // reference model state
  logic [31:0] expAddr = '0;
  logic        expRead = 1'b0;
  logic        expLea = 1'b0;
  string       expTag = "R10";

  always #2 clk = ~clk;   // 250 MHz

  scaled_agu u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .leaReq(leaReq),
    .modeSel(modeSel), .scaleSel(scaleSel), .dispWide(dispWide),
    .baseVal(baseVal), .indexVal(indexVal), .dispVal(dispVal),
    .effAddr(effAddr), .memRead(memRead), .leaWrite(leaWrite)
  );

  function automatic logic [31:0] refAddr();
    logic [31:0] d;
    logic [31:0] mul;
    d   = dispWide ? dispVal : 32'($signed(dispVal[7:0]));
    mul = 32'(1) << scaleSel;
    case (modeSel)
      2'd0:    return baseVal + d;
      2'd1:    return baseVal + indexVal;
      2'd2:    return baseVal + indexVal * mul;
      default: return baseVal + indexVal * mul + d;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN || !reqValid) begin
      expAddr = '0;
      expRead = 1'b0;
      expLea  = 1'b0;
    end else begin
      expAddr = refAddr();
      expRead = !leaReq;
      expLea  = leaReq;
    end
    expTag = rstN ? curTag : "R10";
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (effAddr !== expAddr || memRead !== expRead || leaWrite !== expLea) begin
        mismatched++;
        $display("FAIL %s: addr=%h rd=%b lea=%b expected addr=%h rd=%b lea=%b",
                 expTag, effAddr, memRead, leaWrite, expAddr, expRead, expLea);
      end
    end
  end

  task automatic issue(input string tag, input logic [1:0] mode, input logic [1:0] sc,
                       input logic wide, input logic [31:0] b, input logic [31:0] ix,
                       input logic [31:0] d, input logic lea);
    @(negedge clk);
    curTag   = tag;
    reqValid = 1'b1;
    modeSel  = mode;
    scaleSel = sc;
    dispWide = wide;
    baseVal  = b;
    indexVal = ix;
    dispVal  = d;
    leaReq   = lea;
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    curTag   = tag;
    reqValid = 1'b0;
    baseVal  = 32'hDEAD_BEEF;
    indexVal = 32'h1234_5678;
  endtask

  initial begin
    repeat (4) @(negedge clk);              // reset state compared: R10
    rstN = 1'b1;
    idle("R10");
    issue("R1", 2'd0, 2'd0, 1'b1, 32'h0000_1000, 32'h0, 32'h0000_0020, 1'b0);
    issue("R5", 2'd0, 2'd0, 1'b0, 32'h0000_1000, 32'h0, 32'hABCD_12FC, 1'b0);
    issue("R5", 2'd0, 2'd0, 1'b0, 32'h0000_1000, 32'h0, 32'hFFFF_FF7F, 1'b0);
    issue("R5", 2'd3, 2'd1, 1'b1, 32'h0000_1000, 32'h10, 32'hFFF0_0000, 1'b0);
    issue("R6", 2'd0, 2'd3, 1'b1, 32'h0000_2000, 32'hFFFF_FFFF, 32'h4, 1'b0);
    issue("R2", 2'd1, 2'd3, 1'b1, 32'h0000_3000, 32'h0000_0044, 32'h7777_0000, 1'b0);
    for (int s = 0; s < 4; s++)
      issue("R3", 2'd2, 2'(s), 1'b1, 32'h0000_4000, 32'h0000_0013, 32'h5555_5555, 1'b0);
    issue("R4", 2'd3, 2'd2, 1'b0, 32'h0000_8000, 32'h0000_0100, 32'h0000_00F0, 1'b0);
    issue("R4", 2'd3, 2'd3, 1'b1, 32'h1000_0000, 32'h0000_0007, 32'h0000_0100, 1'b0);
    issue("R7", 2'd0, 2'd0, 1'b1, 32'hFFFF_FFF0, 32'h0, 32'h0000_0020, 1'b0);
    issue("R7", 2'd2, 2'd3, 1'b1, 32'hF000_0000, 32'h4000_0000, 32'h0, 1'b0);
    issue("R8", 2'd3, 2'd2, 1'b1, 32'h0000_0100, 32'h0000_0003, 32'hFFFF_FFFC, 1'b1);
    issue("R8", 2'd1, 2'd0, 1'b0, 32'h0000_0200, 32'h0000_0002, 32'h0, 1'b1);
    issue("R9", 2'd1, 2'd0, 1'b0, 32'h0000_0300, 32'h0000_0002, 32'h0, 1'b0);
    idle("R10");
    issue("R9", 2'd2, 2'd1, 1'b0, 32'h0000_0400, 32'h0000_0008, 32'h0, 1'b0);
    idle("R10");
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(7) == 0) idle("R10");
      else issue("RAND", 2'($urandom), 2'($urandom), 1'($urandom), $urandom,
                 $urandom, $urandom, 1'($urandom));
    end
    idle("R10");
    @(negedge clk);
    rstN = 1'b0;                            // reset clears a pending result: R10
    issue("R10", 2'd1, 2'd0, 1'b1, 32'h10, 32'h10, 32'h0, 1'b0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule